// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the frequency of a fast core clock against a slow 32768 Hz reference clock. The reference drives a free-running divide-by-4 tick generator and a down-counting gate timer. While the gate is open, the core clock runs through a divide-by-177 prescaler into a saturating event counter. The window is exactly 58 ticks long, and the counter is preloaded two ticks high. With these values, every event stands for almost exactly 25 kHz of core clock.

A measurement starts with a one-cycle start pulse in the core domain. Busy stays high while the measurement runs. When the gate closes, the block rounds the raw count and scales it by a registered constant multiply. It then raises done and presents the core frequency in Hz, rounded to 0.1 MHz. A bus-clock figure is derived from it: equal to the core figure, or half of it when the divider-enable input is high. Done and the results hold until the next accepted start.

Top module: `fm_meter`

## Requirements
- R1: After reset, busy_o, done_o, valid_o and ovf_o are low, and count_o, core_hz_o and bus_hz_o are zero.
- R2: A start_i pulse while idle or done raises busy_o and clears done_o on the next core cycle.
- R3: The gate timer counts ticks of the reference divided by 4. It is loaded with 59 and opens once it has decremented to 57. It closes on the tick after it reaches 0, so the window lasts 58 ticks (232 reference cycles).
- R4: The prescaler produces one event per 177 core cycles within the window, so count_o equals floor(232 * Tref / (177 * Tcore)).
- R5: The event counter saturates at 2^CNT_W-1 instead of wrapping. Overflow sets ovf_o, which stays set until the next accepted start. While ovf_o is set, valid_o stays low when done_o is high.
- R6: core_hz_o equals ((count + 2) div 4) * 100000, and is present when done_o rises. valid_o is high with done_o when no overflow occurred.
- R7: bus_hz_o equals core_hz_o when bus_div_i is low, and floor(core_hz_o / 2) when it is high.
- R8: A start_i pulse while busy_o is high has no effect on busy_o or on the result.
- R9: done_o and busy_o are never high together. Once done_o is high, it and all result outputs hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock being measured |
| clk_ref | input | 1 | 32768 Hz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, core domain |
| bus_div_i | input | 1 | Bus divider enable (1 = bus runs at half core) |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Result available |
| valid_o | output | 1 | Done and no overflow |
| ovf_o | output | 1 | Sticky event-counter overflow |
| count_o | output | CNT_W | Captured raw event count |
| core_hz_o | output | CNT_W+16 | Rounded core frequency in Hz |
| bus_hz_o | output | CNT_W+16 | Derived bus frequency in Hz |

## Verification
The hardest case to reach from the ports is a count whose exact value depends on how many core edges fall inside a window timed by an unrelated clock. The bench derives the reference from a period that is an integer multiple of the core period, with edges offset by a quarter core period. This makes the in-window core edge count exactly 232 times that multiple, so every expected count is a fixed integer. The bench reaches overflow by instantiating a narrow counter and stretching the reference period until the count passes the counter's range. It reaches the ignored start by pulsing start in the middle of a window.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SCALE = 2'd2,
    ST_DONE  = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
// Multi-stage flop chain: single-bit CDC, or reset release when d_i is tied high.
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fm_gate.sv
// Reference-domain gate timer: tick divider plus preloaded down-counter.
module fm_gate #(
  parameter int REF_DIV   = 4,
  parameter int WIN_TICKS = 58,
  parameter int LEAD      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl_i,
  output logic open_o,
  output logic done_tgl_o
);
  localparam int LOAD    = WIN_TICKS - 1 + LEAD;
  localparam int OPEN_AT = WIN_TICKS - 1;
  localparam int GW      = $clog2(LOAD + 1);
  localparam int DW      = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  logic          req_s, req_q, req_edge, tick;
  logic [DW-1:0] div_q, div_d;
  logic [GW-1:0] gate_q, gate_d;
  logic          armed_q, armed_d, open_q, open_d, dtg_q, dtg_d;

  fm_sync #(.STAGES(2)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_tgl_i), .q_o(req_s)
  );

  assign req_edge = req_s ^ req_q;
  assign tick     = (div_q == DW'(REF_DIV - 1));

  always_comb begin
    div_d   = tick ? '0 : div_q + 1'b1;
    gate_d  = gate_q;
    armed_d = armed_q;
    open_d  = open_q;
    dtg_d   = dtg_q;
    if (req_edge) begin
      gate_d  = GW'(LOAD);
      armed_d = 1'b1;
      open_d  = 1'b0;
    end else if (armed_q && tick) begin
      if (gate_q == '0) begin
        armed_d = 1'b0;
        open_d  = 1'b0;
        dtg_d   = ~dtg_q;
      end else begin
        gate_d = gate_q - 1'b1;
        if (gate_q <= GW'(OPEN_AT + 1)) open_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      div_q   <= '0;
      gate_q  <= '0;
      armed_q <= 1'b0;
      open_q  <= 1'b0;
      dtg_q   <= 1'b0;
    end else begin
      req_q   <= req_s;
      div_q   <= div_d;
      gate_q  <= gate_d;
      armed_q <= armed_d;
      open_q  <= open_d;
      dtg_q   <= dtg_d;
    end
  end

  assign open_o     = open_q;
  assign done_tgl_o = dtg_q;

  p_gate_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q <= GW'(LOAD));
  p_open_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> armed_q);
  p_open_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> gate_q == GW'(OPEN_AT));
endmodule

// File: rtl/fm_count.sv
// Core-domain prescaler feeding a saturating event counter.
module fm_count #(
  parameter int PRESCALE = 177,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0]    PS_LAST = PW'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CMAX    = '1;

  logic [PW-1:0]    ps_q, ps_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    ps_d  = ps_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr_i) begin
      ps_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (en_i) begin
      if (ps_q == PS_LAST) begin
        ps_d = '0;
        if (cnt_q == CMAX) ovf_d = 1'b1;
        else               cnt_d = cnt_q + 1'b1;
      end else begin
        ps_d = ps_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ps_q  <= ps_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_ps_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q <= PS_LAST);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(cnt_q) && $stable(ps_q));
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clr_i) |=> cnt_q == CMAX);
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/fm_meter.sv
module fm_meter
  import fm_pkg::*;
#(
  parameter int REF_DIV   = 4,
  parameter int WIN_TICKS = 58,
  parameter int LEAD      = 2,
  parameter int PRESCALE  = 177,
  parameter int CNT_W     = 16,
  parameter int HZ_STEP   = 100000,
  localparam int HZ_W     = CNT_W + 16
) (
  input  logic             clk_core,
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bus_div_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] count_o,
  output logic [HZ_W-1:0]  core_hz_o,
  output logic [HZ_W-1:0]  bus_hz_o
);
  localparam int RW = CNT_W - 1;

  logic core_rst_n, ref_rst_n;
  logic open_r, dtg_r, open_s, dtg_s;
  logic req_q, req_d, dtg_q, done_edge;
  logic clr, accept;
  fm_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_live, cap_q, cap_d;
  logic [RW-1:0]    rnd_q, rnd_d;
  logic [HZ_W-1:0]  hz_q, hz_d;
  logic [CNT_W:0]   biased;

  fm_sync #(.STAGES(2)) u_core_rst (
    .clk(clk_core), .rst_n(rst_n), .d_i(1'b1), .q_o(core_rst_n)
  );
  fm_sync #(.STAGES(2)) u_ref_rst (
    .clk(clk_ref), .rst_n(rst_n), .d_i(1'b1), .q_o(ref_rst_n)
  );

  fm_gate #(.REF_DIV(REF_DIV), .WIN_TICKS(WIN_TICKS), .LEAD(LEAD)) u_gate (
    .clk(clk_ref), .rst_n(ref_rst_n), .req_tgl_i(req_q),
    .open_o(open_r), .done_tgl_o(dtg_r)
  );

  fm_sync #(.STAGES(2)) u_open_sync (
    .clk(clk_core), .rst_n(core_rst_n), .d_i(open_r), .q_o(open_s)
  );
  fm_sync #(.STAGES(2)) u_done_sync (
    .clk(clk_core), .rst_n(core_rst_n), .d_i(dtg_r), .q_o(dtg_s)
  );

  fm_count #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_count (
    .clk(clk_core), .rst_n(core_rst_n), .clr_i(clr), .en_i(open_s),
    .cnt_o(cnt_live), .ovf_o(ovf_o)
  );

  assign done_edge = dtg_s ^ dtg_q;
  assign accept    = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign clr       = accept;
  assign biased    = {1'b0, cnt_live} + (CNT_W+1)'(2);

  always_comb begin
    st_d  = st_q;
    req_d = req_q;
    cap_d = cap_q;
    rnd_d = rnd_q;
    hz_d  = hz_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (accept) begin
        req_d = ~req_q;
        st_d  = ST_RUN;
      end
      ST_RUN: if (done_edge) begin
        cap_d = cnt_live;
        rnd_d = biased[CNT_W:2];
        st_d  = ST_SCALE;
      end
      ST_SCALE: begin
        hz_d = HZ_W'(rnd_q) * HZ_W'(HZ_STEP);
        st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_core or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
      dtg_q <= 1'b0;
      cap_q <= '0;
      rnd_q <= '0;
      hz_q  <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      dtg_q <= dtg_s;
      cap_q <= cap_d;
      rnd_q <= rnd_d;
      hz_q  <= hz_d;
    end
  end

  assign busy_o    = (st_q == ST_RUN) || (st_q == ST_SCALE);
  assign done_o    = (st_q == ST_DONE);
  assign valid_o   = done_o && !ovf_o;
  assign count_o   = cap_q;
  assign core_hz_o = hz_q;
  assign bus_hz_o  = bus_div_i ? (hz_q >> 1) : hz_q;

  p_busy_done_r9: assert property (@(posedge clk_core) disable iff (!core_rst_n)
    !(busy_o && done_o));
  p_done_hold_r9: assert property (@(posedge clk_core) disable iff (!core_rst_n)
    (done_o && !start_i) |=> done_o && $stable(core_hz_o) && $stable(count_o));
  p_start_r2: assert property (@(posedge clk_core) disable iff (!core_rst_n)
    (!busy_o && start_i) |=> busy_o && !done_o);
  p_ignore_r8: assert property (@(posedge clk_core) disable iff (!core_rst_n)
    busy_o |=> $stable(req_q));
  p_valid_r5: assert property (@(posedge clk_core) disable iff (!core_rst_n)
    valid_o |-> !ovf_o);
endmodule

// File: tb/sim_fm_meter.sv
module sim_fm_meter;
  localparam int CW = 8;
  localparam int HW = CW + 16;
  localparam int NV = 5;
  // each entry: reference period in core cycles, bus divider enable
  localparam int VEC [NV][2] = '{'{10, 0}, '{23, 1}, '{37, 0}, '{61, 1}, '{150, 0}};

  logic clk = 1'b0, clk_ref = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, bus_div_i = 1'b0;
  logic busy_o, done_o, valid_o, ovf_o;
  logic [CW-1:0] count_o;
  logic [HW-1:0] core_hz_o, bus_hz_o;
  int ref_p = 10;
  int n_chk = 0, n_fail = 0;

  fm_meter #(.CNT_W(CW)) u0 (
    .clk_core(clk), .clk_ref(clk_ref), .rst_n(rst_n), .start_i(start_i),
    .bus_div_i(bus_div_i), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .ovf_o(ovf_o), .count_o(count_o), .core_hz_o(core_hz_o), .bus_hz_o(bus_hz_o)
  );

  always #10 clk = ~clk;
  initial begin
    #5;
    forever #(ref_p * 10) clk_ref = ~clk_ref;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #3_900_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 80000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic longint exp_cnt(input int p);
    longint c = (232 * p) / 177;
    return (c > 255) ? 255 : c;
  endfunction

  function automatic longint exp_hz(input longint c);
    return ((c + 2) / 4) * 100000;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 hz", core_hz_o, 0);
    chk("R1 count", count_o, 0);

    for (int i = 0; i < NV; i++) begin
      longint c, hz;
      ref_p = VEC[i][0];
      bus_div_i = VEC[i][1][0];
      c  = exp_cnt(ref_p);
      hz = exp_hz(c);
      pulse_start();
      chk("R2 busy after start", busy_o, 1);
      chk("R2 done cleared", done_o, 0);
      wait_done();
      chk("R3 R4 count", count_o, c);
      chk("R6 core_hz", core_hz_o, hz);
      chk("R6 valid", valid_o, 1);
      chk("R7 bus_hz", bus_hz_o, bus_div_i ? hz / 2 : hz);
      chk("R9 busy low at done", busy_o, 0);
    end

    // R7: divider toggled while result held
    bus_div_i = 1'b1;
    @(negedge clk);
    chk("R7 bus half", bus_hz_o, exp_hz(exp_cnt(150)) / 2);
    bus_div_i = 1'b0;
    @(negedge clk);
    chk("R7 bus full", bus_hz_o, exp_hz(exp_cnt(150)));

    // R9: hold for many cycles
    repeat (200) @(negedge clk);
    chk("R9 done held", done_o, 1);
    chk("R9 hz held", core_hz_o, exp_hz(exp_cnt(150)));

    // R8: start in mid-window is ignored
    ref_p = 20;
    pulse_start();
    repeat (2000) @(negedge clk);
    pulse_start();
    chk("R8 busy kept", busy_o, 1);
    wait_done();
    chk("R8 count unaffected", count_o, exp_cnt(20));
    chk("R8 hz unaffected", core_hz_o, exp_hz(exp_cnt(20)));
    repeat (3000) @(negedge clk);
    chk("R8 no restart", busy_o, 0);

    // R5: overflow of the narrow counter
    ref_p = 200;
    pulse_start();
    wait_done();
    chk("R5 saturated count", count_o, 255);
    chk("R5 ovf set", ovf_o, 1);
    chk("R5 valid low", valid_o, 0);
    chk("R5 done", done_o, 1);

    // R5: flag clears on next start
    ref_p = 10;
    pulse_start();
    chk("R5 ovf cleared", ovf_o, 0);
    wait_done();
    chk("R5 valid back", valid_o, 1);
    chk("R6 hz small", core_hz_o, exp_hz(exp_cnt(10)));

    finish_run();
  end
endmodule